// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is the bus-facing side of a small sensor register file. It takes the raw clock and data lines of an open-drain two-wire bus (I2C/SMBus-compatible), oversamples them on the system clock, and drives only an SDA pull-down enable. The block answers a 7-bit address whose low bit follows a strap pin. It keeps a 2-bit register pointer that persists between transactions. It streams register words out most significant byte first and hands received bytes to the register file as single-cycle write strobes.

Three bus commands besides plain register access are decoded. The general call address carries a second byte that either re-samples the strap pin or also restores the register file to its power-up values. A high-speed master code is taken silently and flagged until the next STOP. The alert-response address is acknowledged while the alert input is active. The block then sends back its own address with a status bit, and it drops out if another responder wins a bit. A low-line watchdog returns the interface to idle when either line stays low for too long inside a transaction.

Top module: `twi_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 100100 followed by the strap pin value sampled at the last START, and does not acknowledge any other address except those named in R8 and R10.
- R2: In a write, the byte after the address sets the pointer to its two low bits (00 temperature, 01 configuration, 10 low limit, 11 high limit). The pointer reads 00 after reset and is presented on `rd_reg_o`.
- R3: Each further written byte is acknowledged and produces one `wr_valid_o` pulse carrying the pointer, the byte, and `wr_hi_o` set for the first, third, and later odd-numbered bytes. Bytes written with pointer 00 produce no strobe.
- R4: A read addressed to the slave pulses `rd_done_o` once and returns `rd_word_i[15:8]` then `rd_word_i[7:0]`, each MSB first.
- R5: A read with no preceding pointer byte uses the pointer from the most recent write, including across a repeated START.
- R6: When the pointer is 01, bit 7 of the first byte read is always 0.
- R7: A master NACK ends a read and the slave releases SDA.
- R8: General call (address byte 0x00) is acknowledged. A second byte of 0x06 is acknowledged, pulses `gc_reset_o` and clears the pointer to 00. A second byte of 0x04 is acknowledged with no pulse and leaves the pointer unchanged. Any other second byte is not acknowledged.
- R9: A first byte of the form 00001xxx is not acknowledged and sets `hs_mode_o`, which clears at the next STOP.
- R10: With `alert_i` high, the byte 0x19 (0001100 + read) is acknowledged and answered with {100100, strap, `alert_stat_i`}, after which `alert_won_o` pulses. With `alert_i` low it is not acknowledged.
- R11: If SDA reads low while the slave sends a 1 during the alert response, the slave stops driving and `alert_won_o` does not pulse.
- R12: If SCL or SDA stays low for `TIMEOUT_CYC` cycles between START and STOP, the slave releases SDA and ignores bus bits until the next START.
- R13: After reset, `sda_oe_o`, `hs_mode_o` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| sel_pin_i | input | 1 | Address strap, becomes address bit 0 |
| alert_i | input | 1 | Alert currently active |
| alert_stat_i | input | 1 | Status bit returned in the alert response |
| rd_word_i | input | 16 | Word of the register selected by `rd_reg_o` |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| rd_reg_o | output | 2 | Current pointer, selects the read word |
| wr_valid_o | output | 1 | One-cycle write strobe |
| wr_reg_o | output | 2 | Target register of the strobe |
| wr_hi_o | output | 1 | Strobe carries the high byte |
| wr_data_o | output | 8 | Written byte |
| rd_done_o | output | 1 | Pulse when a register read is addressed |
| gc_reset_o | output | 1 | Pulse for a general-call register restore |
| alert_won_o | output | 1 | Pulse when the alert response completes unopposed |
| hs_mode_o | output | 1 | High-speed master code seen since the last STOP |

## Verification
Each line passes two synchronizer flops and an edge register, so the slave reacts three system clocks after an SCL edge. Acknowledge and data bits therefore appear a few clocks after SCL falls, and the bench samples SDA in the middle of the following SCL high phase, several clocks after the bit is due. Strobes are counted by negative-edge monitors. Pointer, `hs_mode_o` and `sda_oe_o` are read only after the bus task that changes them has completed a full quarter period. The address sweep covers all 256 first bytes against an acknowledge and high-speed flag predicted from the byte value.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} twi_st_e;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA, K_GC} twi_kind_e;
  typedef enum logic [1:0] {A_RX, A_TX, A_IDLE} twi_after_e;

  localparam int unsigned NLINES    = 2;
  localparam logic [6:0]  ARA_ADDR  = 7'b0001100;
  localparam logic [7:0]  GC_BYTE   = 8'h00;
  localparam logic [7:0]  GC_LATCH  = 8'h04;
  localparam logic [7:0]  GC_RESET  = 8'h06;
  localparam logic [4:0]  HS_PREFIX = 5'b00001;
  localparam logic [1:0]  PTR_RO    = 2'b00;
  localparam logic [1:0]  PTR_CFG   = 2'b01;
endpackage

// File: rtl/twi_sync_edge.sv
module twi_sync_edge import twi_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  // bit 0 = SCL, bit 1 = SDA
  logic [NLINES-1:0] m1_q, m2_q, prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m1_q  <= '1;
      m2_q  <= '1;
      prv_q <= '1;
    end else begin
      m1_q  <= {sda_i, scl_i};
      m2_q  <= m1_q;
      prv_q <= m2_q;
    end
  end

  assign scl_s_o = m2_q[0];
  assign sda_s_o = m2_q[1];
  assign start_o = m2_q[0] & prv_q[0] & prv_q[1] & ~m2_q[1];
  assign stop_o  = m2_q[0] & prv_q[0] & ~prv_q[1] & m2_q[1];
  assign rise_o  = m2_q[0] & ~prv_q[0];
  assign fall_o  = ~m2_q[0] & prv_q[0];
endmodule

// File: rtl/twi_low_timer.sv
module twi_low_timer #(
  parameter int unsigned LIMIT = 2_700_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i)                  cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT))     cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

  p_cnt_cap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT));
  p_idle_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/twi_slave_core.sv
module twi_slave_core import twi_pkg::*; #(
  parameter logic [5:0] ADDR_BASE = 6'b100100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sda_s_i,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        tmo_i,
  input  logic        sel_pin_i,
  input  logic        alert_i,
  input  logic        alert_stat_i,
  input  logic [15:0] rd_word_i,
  output logic        busy_o,
  output logic        sda_oe_o,
  output logic [1:0]  rd_reg_o,
  output logic        wr_valid_o,
  output logic [1:0]  wr_reg_o,
  output logic        wr_hi_o,
  output logic [7:0]  wr_data_o,
  output logic        rd_done_o,
  output logic        gc_reset_o,
  output logic        alert_won_o,
  output logic        hs_mode_o
);
  twi_st_e    st_q;
  twi_kind_e  kind_q;
  twi_after_e after_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] sh_q;
  logic [1:0] ptr_q;
  logic       byte_lo_q, is_ara_q, mack_q, sel_q, sel_ok_q, busy_q, hs_q;
  logic       wr_valid_q, wr_hi_q, rd_done_q, gc_q, won_q;
  logic [7:0] wr_data_q;
  logic [7:0] hi_byte, tx_byte;
  logic       own_hit;

  always_comb begin
    hi_byte = rd_word_i[15:8];
    if (ptr_q == PTR_CFG) hi_byte[7] = 1'b0;
    if (is_ara_q)       tx_byte = {ADDR_BASE, sel_q, alert_stat_i};
    else if (byte_lo_q) tx_byte = rd_word_i[7:0];
    else                tx_byte = hi_byte;
  end

  assign own_hit = (sh_q[7:1] == {ADDR_BASE, sel_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      kind_q     <= K_ADDR;
      after_q    <= A_IDLE;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      ptr_q      <= PTR_RO;
      byte_lo_q  <= 1'b0;
      is_ara_q   <= 1'b0;
      mack_q     <= 1'b0;
      sel_q      <= 1'b0;
      sel_ok_q   <= 1'b0;
      busy_q     <= 1'b0;
      hs_q       <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_hi_q    <= 1'b0;
      wr_data_q  <= '0;
      rd_done_q  <= 1'b0;
      gc_q       <= 1'b0;
      won_q      <= 1'b0;
    end else begin
      wr_valid_q <= 1'b0;
      rd_done_q  <= 1'b0;
      gc_q       <= 1'b0;
      won_q      <= 1'b0;
      if (!sel_ok_q) begin
        sel_q    <= sel_pin_i;
        sel_ok_q <= 1'b1;
      end
      if (tmo_i) begin
        st_q   <= ST_IDLE;
        busy_q <= 1'b0;
        hs_q   <= 1'b0;
      end else if (start_i) begin
        st_q      <= ST_RX;
        kind_q    <= K_ADDR;
        bit_cnt_q <= '0;
        is_ara_q  <= 1'b0;
        busy_q    <= 1'b1;
        sel_q     <= sel_pin_i;
      end else if (stop_i) begin
        st_q   <= ST_IDLE;
        busy_q <= 1'b0;
        hs_q   <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (rise_i && bit_cnt_q != 4'd8) begin
              sh_q      <= {sh_q[6:0], sda_s_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (fall_i && bit_cnt_q == 4'd8) begin
              unique case (kind_q)
                K_ADDR: begin
                  if (own_hit) begin
                    st_q <= ST_ACK;
                    if (sh_q[0]) begin
                      after_q   <= A_TX;
                      is_ara_q  <= 1'b0;
                      byte_lo_q <= 1'b0;
                      rd_done_q <= 1'b1;
                    end else begin
                      after_q <= A_RX;
                      kind_q  <= K_PTR;
                    end
                  end else if (sh_q == GC_BYTE) begin
                    st_q    <= ST_ACK;
                    after_q <= A_RX;
                    kind_q  <= K_GC;
                  end else if (sh_q[7:3] == HS_PREFIX) begin
                    hs_q <= 1'b1;
                    st_q <= ST_IDLE;
                  end else if (sh_q == {ARA_ADDR, 1'b1} && alert_i) begin
                    st_q     <= ST_ACK;
                    after_q  <= A_TX;
                    is_ara_q <= 1'b1;
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
                K_PTR: begin
                  ptr_q     <= sh_q[1:0];
                  kind_q    <= K_DATA;
                  byte_lo_q <= 1'b0;
                  st_q      <= ST_ACK;
                  after_q   <= A_RX;
                end
                K_DATA: begin
                  st_q      <= ST_ACK;
                  after_q   <= A_RX;
                  byte_lo_q <= ~byte_lo_q;
                  if (ptr_q != PTR_RO) begin
                    wr_valid_q <= 1'b1;
                    wr_hi_q    <= ~byte_lo_q;
                    wr_data_q  <= sh_q;
                  end
                end
                default: begin
                  if (sh_q == GC_LATCH || sh_q == GC_RESET) begin
                    sel_q   <= sel_pin_i;
                    st_q    <= ST_ACK;
                    after_q <= A_IDLE;
                    if (sh_q == GC_RESET) begin
                      gc_q  <= 1'b1;
                      ptr_q <= PTR_RO;
                    end
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (fall_i) begin
              bit_cnt_q <= '0;
              unique case (after_q)
                A_RX:    st_q <= ST_RX;
                A_TX: begin
                  st_q <= ST_TX;
                  sh_q <= tx_byte;
                end
                default: st_q <= ST_IDLE;
              endcase
            end
          end
          ST_TX: begin
            if (rise_i && is_ara_q && sh_q[7] && !sda_s_i) begin
              st_q <= ST_IDLE; // arbitration lost
            end else if (fall_i) begin
              if (bit_cnt_q == 4'd7) begin
                st_q      <= ST_MACK;
                byte_lo_q <= ~byte_lo_q;
                won_q     <= is_ara_q;
              end else begin
                sh_q      <= {sh_q[6:0], 1'b0};
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (rise_i) begin
              mack_q <= ~sda_s_i;
            end else if (fall_i) begin
              if (mack_q && !is_ara_q) begin
                st_q      <= ST_TX;
                sh_q      <= tx_byte;
                bit_cnt_q <= '0;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o      = busy_q;
  assign sda_oe_o    = (st_q == ST_ACK) || (st_q == ST_TX && !sh_q[7]);
  assign rd_reg_o    = ptr_q;
  assign wr_valid_o  = wr_valid_q;
  assign wr_reg_o    = ptr_q;
  assign wr_hi_o     = wr_hi_q;
  assign wr_data_o   = wr_data_q;
  assign rd_done_o   = rd_done_q;
  assign gc_reset_o  = gc_q;
  assign alert_won_o = won_q;
  assign hs_mode_o   = hs_q;

  p_stop_clears_hs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !tmo_i && !start_i |=> !hs_mode_o);
  p_timeout_release_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |=> !sda_oe_o);
  p_no_ro_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> wr_reg_o != PTR_RO);
  p_gc_ptr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_reset_o |-> rd_reg_o == PTR_RO);
  p_rd_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !rd_done_o);
  p_won_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_won_o |=> !alert_won_o && !sda_oe_o);
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave import twi_pkg::*; #(
  parameter int unsigned TIMEOUT_CYC = 2_700_000,
  parameter logic [5:0]  ADDR_BASE   = 6'b100100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        sel_pin_i,
  input  logic        alert_i,
  input  logic        alert_stat_i,
  input  logic [15:0] rd_word_i,
  output logic        sda_oe_o,
  output logic [1:0]  rd_reg_o,
  output logic        wr_valid_o,
  output logic [1:0]  wr_reg_o,
  output logic        wr_hi_o,
  output logic [7:0]  wr_data_o,
  output logic        rd_done_o,
  output logic        gc_reset_o,
  output logic        alert_won_o,
  output logic        hs_mode_o
);
  logic scl_s, sda_s, start, stop, rise, fall, busy, tmo;
  logic [NLINES-1:0] line_low, expired;

  twi_sync_edge u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .scl_s_o (scl_s),
    .sda_s_o (sda_s),
    .start_o (start),
    .stop_o  (stop),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign line_low = {~sda_s, ~scl_s};

  for (genvar g = 0; g < NLINES; g++) begin : g_tmr
    twi_low_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (busy & line_low[g]),
      .expired_o (expired[g])
    );
  end

  assign tmo = |expired;

  twi_slave_core #(.ADDR_BASE(ADDR_BASE)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sda_s_i      (sda_s),
    .start_i      (start),
    .stop_i       (stop),
    .rise_i       (rise),
    .fall_i       (fall),
    .tmo_i        (tmo),
    .sel_pin_i    (sel_pin_i),
    .alert_i      (alert_i),
    .alert_stat_i (alert_stat_i),
    .rd_word_i    (rd_word_i),
    .busy_o       (busy),
    .sda_oe_o     (sda_oe_o),
    .rd_reg_o     (rd_reg_o),
    .wr_valid_o   (wr_valid_o),
    .wr_reg_o     (wr_reg_o),
    .wr_hi_o      (wr_hi_o),
    .wr_data_o    (wr_data_o),
    .rd_done_o    (rd_done_o),
    .gc_reset_o   (gc_reset_o),
    .alert_won_o  (alert_won_o),
    .hs_mode_o    (hs_mode_o)
  );

  p_no_drive_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && !$past(busy) |-> !sda_oe_o);
endmodule

// File: tb/twi_reg_slave_bench.sv
module twi_reg_slave_bench;
  localparam int Q   = 6;
  localparam int TMO = 600;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, other_low = 1'b0;
  logic sel_pin = 1'b0, alert = 1'b0, alert_stat = 1'b0;
  logic sda_oe, wr_valid, wr_hi, rd_done, gc_reset, alert_won, hs_mode;
  logic [1:0] rd_reg, wr_reg;
  logic [7:0] wr_data;
  logic [15:0] rd_word;
  wire sda_line = m_sda & ~sda_oe & ~other_low;

  function automatic logic [15:0] word_of(input logic [1:0] p);
    return {6'b110000, p, 8'h5A ^ {6'd0, p}};
  endfunction
  assign rd_word = word_of(rd_reg);

  twi_reg_slave #(.TIMEOUT_CYC(TMO)) u_twi_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sel_pin_i(sel_pin), .alert_i(alert), .alert_stat_i(alert_stat),
    .rd_word_i(rd_word), .sda_oe_o(sda_oe), .rd_reg_o(rd_reg),
    .wr_valid_o(wr_valid), .wr_reg_o(wr_reg), .wr_hi_o(wr_hi),
    .wr_data_o(wr_data), .rd_done_o(rd_done), .gc_reset_o(gc_reset),
    .alert_won_o(alert_won), .hs_mode_o(hs_mode)
  );

  int n_chk = 0, n_fail = 0;
  int n_wr = 0, n_rd = 0, n_gc = 0, n_won = 0;
  logic [11:0] wr_last = '0, wr_prev = '0; // {reg, hi, pad, data}
  bit done = 1'b0;

  always @(negedge clk) begin
    if (wr_valid) begin
      n_wr++;
      wr_prev = wr_last;
      wr_last = {wr_reg, wr_hi, 1'b0, wr_data};
    end
    if (rd_done)   n_rd++;
    if (gc_reset)  n_gc++;
    if (alert_won) n_won++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_w(input logic b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bit_r(input logic ob, output logic v);
    m_sda = 1'b1; other_low = ~ob; tick(Q); m_scl = 1'b1; tick(Q);
    v = sda_line; tick(Q); m_scl = 1'b0; tick(Q); other_low = 1'b0;
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send(input logic [7:0] b, output logic acked);
    logic v;
    for (int i = 7; i >= 0; i--) bit_w(b[i]);
    bit_r(1'b1, v);
    acked = ~v;
  endtask

  task automatic recv(input logic mack, input logic [7:0] other, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_r(other[i], d[i]);
    bit_w(~mack);
  endtask

  task automatic set_ptr(input logic [1:0] p);
    logic a0, a1;
    bus_start; send(8'h90, a0); send({6'd0, p}, a1); bus_stop;
    chk(a0 && a1, "R2 ptr ack", {a0, a1}, 3);
    chk(rd_reg == p, "R2 pointer", rd_reg, p);
  endtask

  task automatic read_word(output logic [7:0] hi, output logic [7:0] lo);
    logic a;
    bus_start; send(8'h91, a);
    chk(a, "R4 read addr ack", a, 1);
    recv(1'b1, 8'hFF, hi); recv(1'b0, 8'hFF, lo); bus_stop;
  endtask

  initial begin
    repeat (2_000_000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic a, b2;
    logic [7:0] hi, lo, d;
    int r0, w0, g0;
    tick(4); rst_n = 1'b1; tick(4);
    // R13
    chk(!sda_oe && !hs_mode && rd_reg == 2'b00, "R13 reset", {sda_oe, hs_mode, rd_reg}, 0);

    // R1 / R9 sweep of every first byte, strap 0
    for (int b = 0; b < 256; b++) begin
      logic [7:0] bb;
      bit exp_ack, exp_hs;
      bb = 8'(b);
      exp_ack = (bb[7:1] == 7'h48) || (bb == 8'h00);
      exp_hs  = (bb[7:3] == 5'b00001);
      bus_start; send(bb, a);
      chk(a == exp_ack, "R1 ack sweep", a, exp_ack);
      chk(hs_mode == exp_hs, "R9 hs flag", hs_mode, exp_hs);
      if (bb == 8'h91) recv(1'b0, 8'hFF, d);
      bus_stop;
      chk(!hs_mode && !sda_oe, "R9 stop clears", {hs_mode, sda_oe}, 0);
    end

    // R1 strap 1
    sel_pin = 1'b1;
    bus_start; send(8'h92, a); bus_stop;
    chk(a, "R1 strap1 own", a, 1);
    bus_start; send(8'h90, a); bus_stop;
    chk(!a, "R1 strap1 other", a, 0);
    sel_pin = 1'b0;

    // R2 R4 R6 R7 reads over all pointers
    for (int p = 0; p < 4; p++) begin
      logic [15:0] w;
      logic [7:0] eh;
      set_ptr(2'(p));
      w = word_of(2'(p));
      eh = (p == 1) ? (w[15:8] & 8'h7F) : w[15:8];
      r0 = n_rd;
      read_word(hi, lo);
      chk(hi == eh, (p == 1) ? "R6 cfg hi byte" : "R4 hi byte", hi, eh);
      chk(lo == w[7:0], "R4 lo byte", lo, w[7:0]);
      chk(n_rd == r0 + 1, "R4 rd_done", n_rd - r0, 1);
      chk(!sda_oe, "R7 release after nack", sda_oe, 0);
    end

    // R3 writes over all pointers
    for (int p = 0; p < 4; p++) begin
      logic a1, a2, a3;
      w0 = n_wr;
      bus_start; send(8'h90, a); send(8'(p), a1); send(8'h9C, a2); send(8'h3B, a3); bus_stop;
      chk(a && a1 && a2 && a3, "R3 write acks", {a, a1, a2, a3}, 15);
      chk(n_wr == w0 + ((p != 0) ? 2 : 0), "R3 strobe count", n_wr - w0, (p != 0) ? 2 : 0);
      if (p != 0) begin
        chk(wr_prev == {2'(p), 1'b1, 1'b0, 8'h9C}, "R3 first strobe", wr_prev, {2'(p), 2'b10, 8'h9C});
        chk(wr_last == {2'(p), 1'b0, 1'b0, 8'h3B}, "R3 second strobe", wr_last, {2'(p), 2'b00, 8'h3B});
      end
    end

    // R5 sticky pointer (last write used ptr 3), then repeated start
    read_word(hi, lo);
    chk({hi, lo} == word_of(2'd3), "R5 sticky read", {hi, lo}, word_of(2'd3));
    bus_start; send(8'h90, a); send(8'h02, b2);
    bus_start; send(8'h91, a);
    recv(1'b1, 8'hFF, hi); recv(1'b0, 8'hFF, lo); bus_stop;
    chk({hi, lo} == word_of(2'd2), "R5 repeated start read", {hi, lo}, word_of(2'd2));

    // R8 general call
    g0 = n_gc;
    bus_start; send(8'h00, a); send(8'h06, b2); bus_stop;
    chk(a && b2, "R8 reset acks", {a, b2}, 3);
    chk(n_gc == g0 + 1, "R8 reset pulse", n_gc - g0, 1);
    chk(rd_reg == 2'b00, "R8 pointer cleared", rd_reg, 0);
    set_ptr(2'd3);
    bus_start; send(8'h00, a); send(8'h04, b2); bus_stop;
    chk(b2 && n_gc == g0 + 1 && rd_reg == 2'd3, "R8 latch only", {b2, rd_reg}, 7);
    bus_start; send(8'h00, a); send(8'h05, b2); bus_stop;
    chk(!b2, "R8 other cmd nack", b2, 0);

    // R10 alert response
    sel_pin = 1'b1; alert = 1'b1; alert_stat = 1'b1;
    g0 = n_won;
    bus_start; send(8'h19, a); recv(1'b0, 8'hFF, d); bus_stop;
    chk(a, "R10 ara ack", a, 1);
    chk(d == 8'h93, "R10 ara byte", d, 8'h93);
    chk(n_won == g0 + 1, "R10 won pulse", n_won - g0, 1);
    // R11 arbitration lost at bit 1
    bus_start; send(8'h19, a); recv(1'b0, 8'h91, d); bus_stop;
    chk(d == 8'h91, "R11 line value", d, 8'h91);
    chk(n_won == g0 + 1, "R11 no won pulse", n_won - g0, 1);
    chk(!sda_oe, "R11 released", sda_oe, 0);
    alert = 1'b0;
    bus_start; send(8'h19, a); bus_stop;
    chk(!a, "R10 no alert nack", a, 0);
    sel_pin = 1'b0;

    // R12 timeout with SCL held low during the acknowledge
    bus_start;
    for (int i = 7; i >= 0; i--) bit_w(i == 7 || i == 4);
    chk(sda_oe, "R12 ack before hold", sda_oe, 1);
    tick(TMO + 20);
    chk(!sda_oe, "R12 released by timeout", sda_oe, 0);
    send(8'h90, a);
    chk(!a, "R12 ignored until start", a, 0);
    bus_stop;
    set_ptr(2'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule